// File: doc/BRIEF.md
# Dual Comparator Range Matcher

This block watches a bus address stream and reports address hits on two match outputs. It holds two programmable comparator values, A and B. Each bus cycle marked valid is tested against them while the block is armed. A two-bit mapping setting decides how the two comparator results reach the outputs. In split mode each comparator drives its own output. In the two window modes the comparators together bound an inclusive address range. Hits then fire either inside or outside that range on the first output, and the second output stays quiet.

Configuration (the mapping setting and both comparator values) can be read back at any time. It is frozen while the block is armed, so that a running watch cannot be disturbed. The match outputs are registered. A valid, armed bus cycle produces its result on the outputs for exactly the following clock cycle.

Top module: `range_match_unit`

## Requirements
- R1: After synchronous active-high reset, the mapping readback is 2'b00, both comparator readbacks are zero, and both match outputs are low.
- R2: With mapping 2'b00, a valid armed cycle sets match0 in the next cycle exactly when the address equals comparator A. It sets match1 exactly when the address equals comparator B.
- R3: With mapping 2'b01, a valid armed cycle sets match0 in the next cycle exactly when A <= address <= B (both bounds inclusive), and match1 stays low.
- R4: With mapping 2'b10, a valid armed cycle sets match0 in the next cycle exactly when the address is below A or above B, and match1 stays low.
- R5: Mapping 2'b11 behaves exactly like mapping 2'b00.
- R6: Both match outputs are low in any cycle that does not follow a clock edge at which both the valid strobe and the armed input were high.
- R7: A mapping write (map_wr_en high at a clock edge) takes effect only when armed is low; while armed it is ignored. The mapping readback always shows the current setting.
- R8: A comparator write (cmp_wr_en high, cmp_wr_sel 0 selects A, 1 selects B) takes effect only when armed is low; while armed it is ignored. Both values are always readable.
- R9: When A is greater than B, the inside mapping never hits and the outside mapping hits on every valid armed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Address of the current bus cycle |
| bus_valid | input | 1 | High when bus_addr carries a real cycle |
| armed | input | 1 | Watch enable; also locks configuration |
| map_wr_en | input | 1 | Mapping write strobe |
| map_wr_data | input | 2 | New mapping value |
| cmp_wr_en | input | 1 | Comparator value write strobe |
| cmp_wr_sel | input | 1 | Comparator select: 0 = A, 1 = B |
| cmp_wr_data | input | AW | New comparator value |
| map_q | output | 2 | Current mapping readback |
| cmp_a_q | output | AW | Comparator A readback |
| cmp_b_q | output | AW | Comparator B readback |
| match0 | output | 1 | First match pulse |
| match1 | output | 1 | Second match pulse |

## Verification
The assertions assume that the reset is held for at least one edge before any checking starts. They also assume that the armed, strobe and address inputs carry defined levels at every edge, because the properties compare the registered outputs with the configuration that was current one edge earlier. The stimulus is driven only between edges. Random addresses are biased toward the comparator values and their immediate neighbours, so the equality and bound cases come up often. Configuration writes are mixed in at random times, with armed both high and low.

// File: rtl/rmu_pkg.sv
package rmu_pkg;

    localparam int NCMP = 2;
    localparam int SELW = (NCMP > 1) ? $clog2(NCMP) : 1;

    typedef enum logic [1:0] {
        MAP_SPLIT   = 2'b00,
        MAP_INSIDE  = 2'b01,
        MAP_OUTSIDE = 2'b10,
        MAP_RSVD    = 2'b11
    } map_mode_e;

    typedef struct packed {
        logic eq;
        logic ge;
        logic le;
    } cmp_flags_t;

    typedef struct packed {
        logic m1;
        logic m0;
    } match_pair_t;

    function automatic match_pair_t route_hits(
        input map_mode_e  mode,
        input cmp_flags_t fa,
        input cmp_flags_t fb
    );
        match_pair_t r;
        logic        in_win;
        in_win = fa.ge && fb.le;
        r = '0;
        unique case (mode)
            MAP_INSIDE:  r.m0 = in_win;
            MAP_OUTSIDE: r.m0 = !in_win;
            default: begin
                r.m0 = fa.eq;
                r.m1 = fb.eq;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rmu_cfg_regs.sv
module rmu_cfg_regs
    import rmu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            armed,
    input  logic            map_wr_en,
    input  map_mode_e       map_wr,
    input  logic            cmp_wr_en,
    input  logic [SELW-1:0] cmp_wr_sel,
    input  logic [AW-1:0]   cmp_wr_data,
    output map_mode_e       map_q,
    output logic [AW-1:0]   cmp_val [NCMP]
);

    logic unlocked;
    assign unlocked = !armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= MAP_SPLIT;
        end else if (unlocked && map_wr_en) begin
            map_q <= map_wr;
        end
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_val
        localparam logic [SELW-1:0] IDX = SELW'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_val[i] <= '0;
            end else if (unlocked && cmp_wr_en && (cmp_wr_sel == IDX)) begin
                cmp_val[i] <= cmp_wr_data;
            end
        end
    end

endmodule

// File: rtl/rmu_point_cmp.sv
module rmu_point_cmp
    import rmu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_val,
    output cmp_flags_t    flags
);

    always_comb begin
        flags.eq = (addr == ref_val);
        flags.ge = (addr >= ref_val);
        flags.le = (addr <= ref_val);
    end

endmodule

// File: rtl/rmu_match_out.sv
module rmu_match_out
    import rmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  map_mode_e  mode,
    input  cmp_flags_t fa,
    input  cmp_flags_t fb,
    output logic       match0,
    output logic       match1
);

    match_pair_t nxt;
    match_pair_t q;

    always_comb begin
        nxt = route_hits(mode, fa, fb);
        if (!fire) begin
            nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    assign match0 = q.m0;
    assign match1 = q.m1;

endmodule

// File: rtl/range_match_unit.sv
module range_match_unit
    import rmu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_valid,
    input  logic          armed,
    input  logic          map_wr_en,
    input  logic [1:0]    map_wr_data,
    input  logic          cmp_wr_en,
    input  logic          cmp_wr_sel,
    input  logic [AW-1:0] cmp_wr_data,
    output logic [1:0]    map_q,
    output logic [AW-1:0] cmp_a_q,
    output logic [AW-1:0] cmp_b_q,
    output logic          match0,
    output logic          match1
);

    map_mode_e     mode;
    logic [AW-1:0] vals  [NCMP];
    cmp_flags_t    flags [NCMP];

    rmu_cfg_regs #(.AW(AW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .armed      (armed),
        .map_wr_en  (map_wr_en),
        .map_wr     (map_mode_e'(map_wr_data)),
        .cmp_wr_en  (cmp_wr_en),
        .cmp_wr_sel (SELW'(cmp_wr_sel)),
        .cmp_wr_data(cmp_wr_data),
        .map_q      (mode),
        .cmp_val    (vals)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        rmu_point_cmp #(.AW(AW)) u_pc (
            .addr   (bus_addr),
            .ref_val(vals[i]),
            .flags  (flags[i])
        );
    end

    rmu_match_out u_out (
        .clk   (clk),
        .rst   (rst),
        .fire  (bus_valid && armed),
        .mode  (mode),
        .fa    (flags[0]),
        .fb    (flags[1]),
        .match0(match0),
        .match1(match1)
    );

    assign map_q   = mode;
    assign cmp_a_q = vals[0];
    assign cmp_b_q = vals[1];

endmodule

// File: rtl/rmu_checker.sv
module rmu_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_valid,
    input logic          armed,
    input logic          map_wr_en,
    input logic          cmp_wr_en,
    input logic [1:0]    map_q,
    input logic [AW-1:0] cmp_a_q,
    input logic [AW-1:0] cmp_b_q,
    input logic          match0,
    input logic          match1
);

    logic fire;
    assign fire = bus_valid && armed;

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !fire |=> (!match0 && !match1));

    // R3 and R4: window modes keep the second output low
    assert_m1_off_R4: assert property (@(posedge clk) disable iff (rst)
        (map_q == 2'b01 || map_q == 2'b10) |=> !match1);

    assert_inside_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && map_q == 2'b01 && bus_addr >= cmp_a_q && bus_addr <= cmp_b_q)
        |=> match0);

    assert_split_a_R2: assert property (@(posedge clk) disable iff (rst)
        (fire && map_q == 2'b00 && bus_addr == cmp_a_q) |=> match0);

    assert_map_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && map_wr_en) |=> $stable(map_q));

    assert_cmp_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && cmp_wr_en) |=> ($stable(cmp_a_q) && $stable(cmp_b_q)));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!match0 && !match1 && map_q == 2'b00));

endmodule

bind range_match_unit rmu_checker #(.AW(AW)) u_rmu_checker (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_valid(bus_valid),
    .armed    (armed),
    .map_wr_en(map_wr_en),
    .cmp_wr_en(cmp_wr_en),
    .map_q    (map_q),
    .cmp_a_q  (cmp_a_q),
    .cmp_b_q  (cmp_b_q),
    .match0   (match0),
    .match1   (match1)
);

// File: tb/range_match_unit_bench.sv
module range_match_unit_bench;

    localparam int AW       = 16;
    localparam int CLK_PER  = 10;
    localparam int WDOG_MAX = 20000;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] bus_addr;
    logic          bus_valid;
    logic          armed;
    logic          map_wr_en;
    logic [1:0]    map_wr_data;
    logic          cmp_wr_en;
    logic          cmp_wr_sel;
    logic [AW-1:0] cmp_wr_data;
    logic [1:0]    map_q;
    logic [AW-1:0] cmp_a_q;
    logic [AW-1:0] cmp_b_q;
    logic          match0;
    logic          match1;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    logic [1:0]    e_map;
    logic [AW-1:0] e_a;
    logic [AW-1:0] e_b;

    always #(CLK_PER / 2) clk = ~clk;

    range_match_unit #(.AW(AW)) u_range_match_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_valid(bus_valid),
        .armed(armed), .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_sel(cmp_wr_sel), .cmp_wr_data(cmp_wr_data),
        .map_q(map_q), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q),
        .match0(match0), .match1(match1)
    );

    function automatic logic exp_m0(input logic [1:0] m, input logic [AW-1:0] a,
                                    input logic [AW-1:0] b, input logic [AW-1:0] ad,
                                    input logic fire);
        if (!fire) return 1'b0;
        case (m)
            2'b01:   return (ad >= a) && (ad <= b);
            2'b10:   return (ad < a) || (ad > b);
            default: return ad == a;
        endcase
    endfunction

    function automatic logic exp_m1(input logic [1:0] m, input logic [AW-1:0] b,
                                    input logic [AW-1:0] ad, input logic fire);
        if (!fire) return 1'b0;
        if (m == 2'b01 || m == 2'b10) return 1'b0;
        return ad == b;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic arm,
                        input logic [AW-1:0] ad, input logic mwe, input logic [1:0] md,
                        input logic cwe, input logic cs, input logic [AW-1:0] cd);
        logic x0, x1;
        bus_valid   = v;   armed     = arm; bus_addr   = ad;
        map_wr_en   = mwe; map_wr_data = md;
        cmp_wr_en   = cwe; cmp_wr_sel  = cs; cmp_wr_data = cd;
        x0 = exp_m0(e_map, e_a, e_b, ad, v && arm);
        x1 = exp_m1(e_map, e_b, ad, v && arm);
        @(posedge clk);
        if (!arm && mwe) e_map = md;
        if (!arm && cwe) begin
            if (cs) e_b = cd; else e_a = cd;
        end
        @(negedge clk);
        check(tag, "match0", AW'(match0), AW'(x0));
        check(tag, "match1", AW'(match1), AW'(x1));
        check("R7", "map_q", AW'(map_q), AW'(e_map));
        check("R8", "cmp_a_q", cmp_a_q, e_a);
        check("R8", "cmp_b_q", cmp_b_q, e_b);
    endtask

    task automatic cfg(input logic [1:0] m, input logic [AW-1:0] a, input logic [AW-1:0] b);
        step("R6", 1'b0, 1'b0, '0, 1'b1, m, 1'b1, 1'b0, a);
        step("R6", 1'b0, 1'b0, '0, 1'b0, 2'b00, 1'b1, 1'b1, b);
    endtask

    task automatic hit(input string tag, input logic [AW-1:0] ad);
        step(tag, 1'b1, 1'b1, ad, 1'b0, 2'b00, 1'b0, 1'b0, '0);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_MAX) begin
                n_fail++;
                n_tests++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, WDOG_MAX);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_addr = '0; bus_valid = 1'b0; armed = 1'b0;
        map_wr_en = 1'b0; map_wr_data = '0; cmp_wr_en = 1'b0;
        cmp_wr_sel = 1'b0; cmp_wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        e_map = 2'b00; e_a = '0; e_b = '0;
        // R1: reset state
        check("R1", "match0", AW'(match0), '0);
        check("R1", "match1", AW'(match1), '0);
        check("R1", "map_q", AW'(map_q), '0);
        check("R1", "cmp_a_q", cmp_a_q, '0);
        check("R1", "cmp_b_q", cmp_b_q, '0);

        // R2: split mapping
        cfg(2'b00, 16'h0100, 16'h0200);
        hit("R2", 16'h0100);
        hit("R2", 16'h0200);
        hit("R2", 16'h0150);
        // R6: no strobe or not armed
        step("R6", 1'b0, 1'b1, 16'h0100, 1'b0, 2'b00, 1'b0, 1'b0, '0);
        step("R6", 1'b1, 1'b0, 16'h0100, 1'b0, 2'b00, 1'b0, 1'b0, '0);
        // R3: inside window, both bounds
        cfg(2'b01, 16'h0100, 16'h0200);
        hit("R3", 16'h0100);
        hit("R3", 16'h0200);
        hit("R3", 16'h00FF);
        hit("R3", 16'h0201);
        // R4: outside window
        cfg(2'b10, 16'h0100, 16'h0200);
        hit("R4", 16'h00FF);
        hit("R4", 16'h0100);
        hit("R4", 16'h0201);
        // R5: reserved code behaves as split
        cfg(2'b11, 16'h0100, 16'h0200);
        hit("R5", 16'h0200);
        hit("R5", 16'h0100);
        // R7 / R8: writes while armed are dropped
        step("R7", 1'b0, 1'b1, '0, 1'b1, 2'b01, 1'b0, 1'b0, '0);
        step("R8", 1'b0, 1'b1, '0, 1'b0, 2'b00, 1'b1, 1'b0, 16'h0BAD);
        step("R8", 1'b0, 1'b1, '0, 1'b0, 2'b00, 1'b1, 1'b1, 16'h0BAD);
        hit("R5", 16'h0200);
        // R9: inverted bounds
        cfg(2'b01, 16'h0300, 16'h0200);
        hit("R9", 16'h0250);
        hit("R9", 16'h0300);
        cfg(2'b10, 16'h0300, 16'h0200);
        hit("R9", 16'h0250);
        hit("R9", 16'h0000);

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] ad;
            logic [2:0]    pick;
            string         tg;
            pick = 3'($urandom_range(0, 5));
            case (pick)
                3'd0: ad = e_a;
                3'd1: ad = e_b;
                3'd2: ad = e_a - 1'b1;
                3'd3: ad = e_b + 1'b1;
                default: ad = AW'($urandom);
            endcase
            case (e_map)
                2'b01:   tg = "R3";
                2'b10:   tg = "R4";
                2'b11:   tg = "R5";
                default: tg = "R2";
            endcase
            step(tg, 1'($urandom), 1'($urandom_range(0, 3) != 0), ad,
                 ($urandom_range(0, 7) == 0), 2'($urandom),
                 ($urandom_range(0, 7) == 0), 1'($urandom),
                 16'h0100 + AW'($urandom_range(0, 255)));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule